// File: doc/BRIEF.md
# Dual-Bank Video Memory Address Mapper

This block sits on the CPU side of a video memory built from two 32-bit banks that hold half of the storage each. A request carries an address, an access size, a write flag and write data. The block turns the request into a bank select, a word address inside that bank, byte-lane enables and lane-aligned write data. One cycle after the request it drives these to the banks as a registered access.

One address bit picks between two aliased views of the same storage. With that bit set, the view is sequential: the lower half of the offset space is the first bank and the upper half is the second. With it clear, the view is interleaved: consecutive 32-bit words alternate between the banks, so the pair of banks behaves as one 64-bit memory.

Reads of any width come back zero-extended from the addressed byte lane. The memory has no byte-write path, so byte writes are refused. Misaligned or reserved-size accesses are also refused. Each refusal raises a sticky error flag.

Top module: `vram_bank_mapper`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `bank_req`, `rd_valid` and `err_flag` are low.
- R2: When address bit VIEW_BIT (24) is 1, the view is sequential: `bank_sel` equals offset bit 22 and `bank_addr` equals offset bits 21:2.
- R3: When address bit VIEW_BIT is 0, the view is interleaved: `bank_sel` equals offset bit 2 and `bank_addr` equals offset bits 22:3.
- R4: Size code 0 is byte, 1 is half-word and 2 is word. An accepted request appears on `bank_req` on the next cycle. The lane enables are `0001<<a[1:0]` for a byte, `0011<<a[1:0]` for a half-word and `1111` for a word. Write data is shifted left by 8·a[1:0] bits.
- R5: An accepted read of any size raises `rd_valid` two cycles after the request. `rd_data` then holds the addressed bytes of the selected bank, zero-extended.
- R6: A write with size code 0 makes no bank access and sets `err_flag`.
- R7: A half-word access with a[0]=1, a word access with a[1:0]≠0, and any access with size code 3 make no bank access and set `err_flag`.
- R8: Once set, `err_flag` stays high until `err_clr` is pulsed. A refusal in the same cycle as `err_clr` leaves the flag set.
- R9: Address bits between the offset and VIEW_BIT have no effect on the mapping.
- R10: Data written through one view reads back through the other view at the location given by R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | View bit, ignored bits, byte offset |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_wdata | input | 32 | Write data, right-aligned |
| err_clr | input | 1 | Clears the sticky error flag |
| bank_req | output | 1 | Bank access this cycle |
| bank_sel | output | 1 | 0 = first bank, 1 = second bank |
| bank_we | output | 1 | Bank write strobe qualifier |
| bank_addr | output | 20 | Word address inside the bank |
| bank_be | output | 4 | Byte-lane enables |
| bank_wdata | output | 32 | Lane-aligned write data |
| bank0_rdata | input | 32 | Read word from first bank, one cycle after access |
| bank1_rdata | input | 32 | Read word from second bank, one cycle after access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Zero-extended read result |
| err_flag | output | 1 | Sticky refusal flag |

## Verification
A wrong bank or word decode does not stay hidden. It shows on `bank_sel` or `bank_addr` one cycle after the request, and it also shows as wrong data when the same storage is read back through the other view. A wrong lane offset held in the read pipeline corrupts `rd_data` in the cycle that `rd_valid` rises. An error flag that is wrongly cleared or set shows on `err_flag` one cycle after the causing request or clear.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam int unsigned LANES = 4;
endpackage

// File: rtl/vbm_rst_sync.sv
module vbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/vbm_view_map.sv
// Maps an offset (byte bits 1:0 removed) to bank and bank-local word.
module vbm_view_map #(
  parameter int OFFSET_W = 23,
  localparam int WORD_AW = OFFSET_W - 3
) (
  input  logic                  seq_view,
  input  logic [OFFSET_W-1:2]   word_off,
  output logic                  bank,
  output logic [WORD_AW-1:0]    word
);
  always_comb begin
    if (seq_view) begin
      // sequential: top offset bit splits the space in halves
      bank = word_off[OFFSET_W-1];
      word = word_off[OFFSET_W-2:2];
    end else begin
      // interleaved: alternate banks every 32-bit word
      bank = word_off[2];
      word = word_off[OFFSET_W-1:3];
    end
  end
endmodule

// File: rtl/vbm_lane_gen.sv
// Legality check, byte enables and write-data placement.
module vbm_lane_gen
  import vbm_pkg::*;
(
  input  logic        we,
  input  logic [1:0]  size,
  input  logic [1:0]  lane,
  input  logic [31:0] wdata,
  output logic        legal,
  output logic [3:0]  be,
  output logic [31:0] wdata_lanes
);
  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: begin
        legal = !we;
        be    = 4'b0001 << lane;
      end
      SZ_HALF: begin
        legal = !lane[0];
        be    = 4'b0011 << lane;
      end
      SZ_WORD: begin
        legal = (lane == 2'b00);
        be    = 4'b1111;
      end
      default: begin
        legal = 1'b0;
        be    = 4'b0000;
      end
    endcase
    wdata_lanes = wdata << {lane, 3'b000};
  end
endmodule

// File: rtl/vbm_rd_steer.sv
// Selects the bank read word and extracts the addressed bytes.
module vbm_rd_steer
  import vbm_pkg::*;
(
  input  logic        sel,
  input  logic [1:0]  lane,
  input  logic [1:0]  size,
  input  logic [31:0] rdata0,
  input  logic [31:0] rdata1,
  output logic [31:0] data
);
  logic [31:0]          word_sel;
  logic [2:0]           nbytes;
  logic [LANES-1:0][7:0] out_bytes;

  assign word_sel = sel ? rdata1 : rdata0;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: nbytes = 3'd1;
      SZ_HALF: nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    logic [2:0] src;
    logic       keep;
    assign src  = {1'b0, lane} + 3'(g);
    assign keep = (src < 3'd4) && (3'(g) < nbytes);
    assign out_bytes[g] = keep ? word_sel[{src[1:0], 3'b000} +: 8] : 8'h00;
  end

  assign data = out_bytes;
endmodule

// File: rtl/vram_bank_mapper.sv
module vram_bank_mapper #(
  parameter int OFFSET_W = 23,
  parameter int VIEW_BIT = 24,
  localparam int ADDR_W  = VIEW_BIT + 1,
  localparam int WORD_AW = OFFSET_W - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  input  logic               err_clr,
  output logic               bank_req,
  output logic               bank_sel,
  output logic               bank_we,
  output logic [WORD_AW-1:0] bank_addr,
  output logic [3:0]         bank_be,
  output logic [31:0]        bank_wdata,
  input  logic [31:0]        bank0_rdata,
  input  logic [31:0]        bank1_rdata,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               err_flag
);
  logic rst_sync_n;

  vbm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // bits between the offset and the view select take no part
  if (VIEW_BIT > OFFSET_W) begin : g_gap
    logic gap_unused;
    assign gap_unused = ^req_addr[VIEW_BIT-1:OFFSET_W];
  end

  // decode
  logic               map_bank;
  logic [WORD_AW-1:0] map_word;
  logic               lg_legal;
  logic [3:0]         lg_be;
  logic [31:0]        lg_wdata;

  vbm_view_map #(.OFFSET_W(OFFSET_W)) u_map (
    .seq_view (req_addr[VIEW_BIT]),
    .word_off (req_addr[OFFSET_W-1:2]),
    .bank     (map_bank),
    .word     (map_word)
  );

  vbm_lane_gen u_lane (
    .we          (req_we),
    .size        (req_size),
    .lane        (req_addr[1:0]),
    .wdata       (req_wdata),
    .legal       (lg_legal),
    .be          (lg_be),
    .wdata_lanes (lg_wdata)
  );

  // stage registers
  logic               s1_req_q, s1_req_d;
  logic               s1_we_q, s1_sel_q;
  logic [WORD_AW-1:0] s1_addr_q;
  logic [3:0]         s1_be_q;
  logic [31:0]        s1_wdata_q;
  logic [1:0]         s1_lane_q, s1_size_q;
  logic               s2_rd_q, s2_rd_d;
  logic               s2_sel_q;
  logic [1:0]         s2_lane_q, s2_size_q;
  logic               err_q, err_d;
  logic               accept, refuse;

  always_comb begin
    accept   = req_valid && lg_legal;
    refuse   = req_valid && !lg_legal;
    s1_req_d = accept;
    s2_rd_d  = s1_req_q && !s1_we_q;
    if (refuse)       err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_req_q <= 1'b0;
      s2_rd_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      s1_req_q <= s1_req_d;
      s2_rd_q  <= s2_rd_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_we_q    <= req_we;
      s1_sel_q   <= map_bank;
      s1_addr_q  <= map_word;
      s1_be_q    <= lg_be;
      s1_wdata_q <= lg_wdata;
      s1_lane_q  <= req_addr[1:0];
      s1_size_q  <= req_size;
    end
    if (s1_req_q) begin
      s2_sel_q  <= s1_sel_q;
      s2_lane_q <= s1_lane_q;
      s2_size_q <= s1_size_q;
    end
  end

  vbm_rd_steer u_steer (
    .sel    (s2_sel_q),
    .lane   (s2_lane_q),
    .size   (s2_size_q),
    .rdata0 (bank0_rdata),
    .rdata1 (bank1_rdata),
    .data   (rd_data)
  );

  assign bank_req   = s1_req_q;
  assign bank_sel   = s1_sel_q;
  assign bank_we    = s1_we_q;
  assign bank_addr  = s1_addr_q;
  assign bank_be    = s1_be_q;
  assign bank_wdata = s1_wdata_q;
  assign rd_valid   = s2_rd_q;
  assign err_flag   = err_q;
endmodule

// File: rtl/vram_bank_mapper_sva.sv
module vram_bank_mapper_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_we,
  input logic [1:0] req_size,
  input logic       view_sel,
  input logic       a_bank_seq,
  input logic       a_bank_il,
  input logic [1:0] a_lo,
  input logic       err_clr,
  input logic       bank_req,
  input logic       bank_sel,
  input logic       bank_we,
  input logic [3:0] bank_be,
  input logic       rd_valid,
  input logic       err_flag
);
  logic word_ok, bad_align;
  assign word_ok   = req_valid && req_size == 2'd2 && a_lo == 2'b00;
  assign bad_align = req_valid && ((req_size == 2'd1 && a_lo[0]) ||
                                   (req_size == 2'd2 && a_lo != 2'b00) ||
                                   req_size == 2'd3);

  AST_SEQ_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok && view_sel |=> bank_req && bank_sel == $past(a_bank_seq)); // R2
  AST_IL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    word_ok && !view_sel |=> bank_req && bank_sel == $past(a_bank_il)); // R3
  AST_BYTE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_we && req_size == 2'd0 |=> !bank_req && err_flag); // R6
  AST_WRITE_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req && bank_we |-> $countones(bank_be) >= 2); // R6
  AST_MISALIGN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    bad_align |=> !bank_req && err_flag); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !req_valid |=> !err_flag); // R8
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req && !bank_we |=> rd_valid); // R5
  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bank_req && !bank_we)); // R5
endmodule

bind vram_bank_mapper vram_bank_mapper_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_we     (req_we),
  .req_size   (req_size),
  .view_sel   (req_addr[VIEW_BIT]),
  .a_bank_seq (req_addr[OFFSET_W-1]),
  .a_bank_il  (req_addr[2]),
  .a_lo       (req_addr[1:0]),
  .err_clr    (err_clr),
  .bank_req   (bank_req),
  .bank_sel   (bank_sel),
  .bank_we    (bank_we),
  .bank_be    (bank_be),
  .rd_valid   (rd_valid),
  .err_flag   (err_flag)
);

// File: tb/vram_bank_mapper_test.sv
`timescale 1ns/1ps
module vram_bank_mapper_test;
  localparam int OW = 8;
  localparam int VB = 9;
  localparam int AW = VB + 1;
  localparam int WA = OW - 3;
  localparam int NB = 1 << OW;

  logic          clk, rst_n;
  logic          req_valid, req_we, err_clr;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [31:0]   req_wdata;
  logic          bank_req, bank_sel, bank_we, rd_valid, err_flag;
  logic [WA-1:0] bank_addr;
  logic [3:0]    bank_be;
  logic [31:0]   bank_wdata, bank0_rdata, bank1_rdata, rd_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [7:0] bmem    [NB];
  logic [7:0] ref_mem [NB];

  vram_bank_mapper #(.OFFSET_W(OW), .VIEW_BIT(VB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .err_clr(err_clr), .bank_req(bank_req), .bank_sel(bank_sel),
    .bank_we(bank_we), .bank_addr(bank_addr), .bank_be(bank_be),
    .bank_wdata(bank_wdata), .bank0_rdata(bank0_rdata),
    .bank1_rdata(bank1_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // synchronous bank model: byte-addressed physical array, bank in MSB
  always @(posedge clk) begin
    if (bank_req) begin
      if (bank_we) begin
        for (int i = 0; i < 4; i++)
          if (bank_be[i]) bmem[{bank_sel, bank_addr, 2'(i)}] <= bank_wdata[8*i +: 8];
      end else begin
        for (int i = 0; i < 4; i++) begin
          if (bank_sel) bank1_rdata[8*i +: 8] <= bmem[{1'b1, bank_addr, 2'(i)}];
          else          bank0_rdata[8*i +: 8] <= bmem[{1'b0, bank_addr, 2'(i)}];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] phys_of(input logic [AW-1:0] a);
    logic [OW-1:0] off;
    off = a[OW-1:0];
    if (a[VB]) return off;
    return {off[2], off[OW-1:3], off[1:0]};
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit is_legal(input logic we, input logic [AW-1:0] a,
                                  input logic [1:0] sz);
    case (sz)
      2'd0: return !we;
      2'd1: return !a[0];
      2'd2: return a[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  task automatic access(input logic we, input logic [AW-1:0] a,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input string tag);
    bit            lg;
    logic [OW-1:0] ph;
    logic [3:0]    ebe;
    logic [31:0]   msk, erd;
    lg  = is_legal(we, a, sz);
    ph  = phys_of(a);
    ebe = (sz == 2'd0) ? (4'b0001 << a[1:0]) :
          (sz == 2'd1) ? (4'b0011 << a[1:0]) : 4'b1111;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (lg) begin
      chk(bank_req === 1'b1, "R4", "bank_req", 32'(bank_req), 32'd1);
      chk(bank_sel === ph[OW-1], tag, "bank_sel", 32'(bank_sel), 32'(ph[OW-1]));
      chk(bank_addr === ph[OW-2:2], tag, "bank_addr", 32'(bank_addr), 32'(ph[OW-2:2]));
      chk(bank_be === ebe, "R4", "bank_be", 32'(bank_be), 32'(ebe));
      if (we) begin
        msk = 32'h0;
        for (int i = 0; i < 4; i++) if (ebe[i]) msk[8*i +: 8] = 8'hFF;
        chk((bank_wdata & msk) === ((wd << (8 * a[1:0])) & msk), "R4", "bank_wdata",
            bank_wdata & msk, (wd << (8 * a[1:0])) & msk);
      end
    end else begin
      chk(bank_req === 1'b0, (sz == 2'd0) ? "R6" : "R7", "refused bank_req",
          32'(bank_req), 32'd0);
      chk(err_flag === 1'b1, (sz == 2'd0) ? "R6" : "R7", "err_flag",
          32'(err_flag), 32'd1);
    end
    @(negedge clk);
    if (lg && !we) begin
      erd = 32'h0;
      for (int i = 0; i < nbytes(sz); i++) erd[8*i +: 8] = ref_mem[ph + OW'(i)];
      chk(rd_valid === 1'b1, "R5", "rd_valid", 32'(rd_valid), 32'd1);
      chk(rd_data === erd, tag, "rd_data", rd_data, erd);
    end else begin
      chk(rd_valid === 1'b0, "R5", "rd_valid idle", 32'(rd_valid), 32'd0);
    end
    if (lg && we)
      for (int i = 0; i < nbytes(sz); i++) ref_mem[ph + OW'(i)] = wd[8*i +: 8];
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err_flag === 1'b0, "R8", "err after clear", 32'(err_flag), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_size = 2'd0;
    req_wdata = '0; err_clr = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < NB; i++) begin bmem[i] = 8'h00; ref_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(bank_req === 1'b0 && rd_valid === 1'b0 && err_flag === 1'b0, "R1",
        "in reset", {29'd0, bank_req, rd_valid, err_flag}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bank_req === 1'b0 && rd_valid === 1'b0 && err_flag === 1'b0, "R1",
        "after reset", {29'd0, bank_req, rd_valid, err_flag}, 32'd0);

    // R3: fill every word through the interleaved view
    for (int w = 0; w < NB / 4; w++) begin
      logic [7:0] o;
      o = 8'(w * 4);
      access(1'b1, {1'b0, 1'b0, o}, 2'd2, {o ^ 8'h5A, o + 8'd3, ~o, o + 8'd1}, "R3");
    end
    // R2 R5 R10: byte reads of all offsets through the sequential view
    for (int b = 0; b < NB; b++)
      access(1'b0, {1'b1, 1'b0, 8'(b)}, 2'd0, 32'h0, "R10");
    // R9: half writes in the sequential view with the ignored bit set
    for (int h = 0; h < NB / 2; h += 3)
      access(1'b1, {1'b1, 1'b1, 8'(h * 2)}, 2'd1, 32'hBEEF0000 | 32'(h * 7), "R9");
    // R10: word reads of every word through the interleaved view
    for (int w = 0; w < NB / 4; w++)
      access(1'b0, {1'b0, 1'b0, 8'(w * 4)}, 2'd2, 32'h0, "R10");
    // R5: half reads at every aligned half offset, interleaved, ignored bit set
    for (int h = 0; h < NB / 2; h++)
      access(1'b0, {1'b0, 1'b1, 8'(h * 2)}, 2'd1, 32'h0, "R5");

    // R6: byte writes are refused and leave memory unchanged
    for (int b = 0; b < 8; b++)
      access(1'b1, {1'(b & 1), 1'b0, 8'(b * 37)}, 2'd0, 32'h000000EE, "R6");
    // R8: sticky across legal traffic
    access(1'b0, {1'b0, 1'b0, 8'h10}, 2'd2, 32'h0, "R8");
    chk(err_flag === 1'b1, "R8", "sticky", 32'(err_flag), 32'd1);
    clear_err();
    for (int b = 0; b < 8; b++)
      access(1'b0, {1'b1, 1'b0, 8'(b * 37) & 8'hFC}, 2'd2, 32'h0, "R6");

    // R7: misaligned and reserved-size accesses
    for (int l = 1; l < 4; l++) begin
      access(1'b1, {1'b0, 1'b0, 8'(64 + l)}, 2'd2, 32'h12345678, "R7");
      access(1'b0, {1'b1, 1'b0, 8'(64 + l)}, 2'd2, 32'h0, "R7");
    end
    access(1'b1, {1'b1, 1'b0, 8'd33}, 2'd1, 32'h0000AAAA, "R7");
    access(1'b0, {1'b0, 1'b0, 8'd35}, 2'd1, 32'h0, "R7");
    access(1'b1, {1'b0, 1'b0, 8'd0}, 2'd3, 32'hFFFFFFFF, "R7");
    access(1'b0, {1'b1, 1'b0, 8'd4}, 2'd3, 32'h0, "R7");
    clear_err();
    for (int w = 16; w < 20; w++)
      access(1'b0, {1'b0, 1'b0, 8'(w * 4)}, 2'd2, 32'h0, "R7");
    access(1'b0, {1'b0, 1'b0, 8'd0}, 2'd2, 32'h0, "R7");
    access(1'b0, {1'b1, 1'b0, 8'd32}, 2'd2, 32'h0, "R7");

    // R8: refusal in the same cycle as a clear keeps the flag
    @(negedge clk);
    err_clr = 1'b1; req_valid = 1'b1; req_we = 1'b1; req_size = 2'd0;
    req_addr = '0;
    @(negedge clk);
    err_clr = 1'b0; req_valid = 1'b0;
    chk(err_flag === 1'b1, "R8", "set wins over clear", 32'(err_flag), 32'd1);
    clear_err();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule